// File: doc/BRIEF.md
# Virtual-Channel Router Input Port

This block is the receiving side of one port of a wormhole network-on-chip router. The link delivers at most one flit per cycle. Each flit carries a virtual-channel index, a flit kind, a destination field and a payload. The virtual channels are grouped into virtual networks. Each channel has its own FIFO and its own packet state, which is either idle or active. When a head flit arrives, the block computes an output port from its destination. It stores that port in the channel, and all later flits of the packet use it.

A buffered flit becomes visible to the switch allocator only after the router's pipeline latency has passed. Only the oldest flit of each channel drives its request bit. When the allocator grants a requesting channel, the block removes that flit. One cycle later it returns a credit upstream that names the channel and says whether the channel is now free. Flits that break the packet protocol, or that arrive at a full FIFO, are dropped and reported with an error pulse.

Per virtual network, the block counts buffer writes and buffer reads. Each accepted flit counts once as a write and once as a read. A synchronous clear resets the counters.

Top module: `vc_input_port`

## Requirements
- R1: After reset, every channel is idle. No request bit, credit or error pulse is asserted, and all buffer counters read zero.
- R2: A flit of kind HEAD (code 0) or HEAD_TAIL (code 3) on an idle channel is accepted and makes that channel active from the next cycle. The block stores the output port `in_dest % NUM_PORTS` for that channel. While `grant_vc` selects the channel, `out_port` shows the stored port.
- R3: A flit of kind BODY (code 1) or TAIL (code 2) on an active channel is accepted. It uses the port stored by the head flit, and its own destination field is ignored.
- R4: The block drops a flit and raises `proto_err` for exactly the next cycle in any of these cases: a head-kind flit on an active channel, a body or tail flit on an idle channel, a channel index out of range, or a flit to a channel whose FIFO is already full at that edge. A dropped flit changes no counter and no channel state.
- R5: A flit sampled at the edge that ends cycle t raises its channel's request bit in cycle t+STAGES. That is STAGES-1 cycles after the first cycle it sits in the buffer. Only the oldest entry of a channel drives the request bit. Once the request bit is high, it stays high until that flit is granted.
- R6: Each channel keeps its flits in arrival order. While `grant_vc` selects a channel, `out_data` and `out_kind` show that channel's oldest flit. No channel holds more than DEPTH flits.
- R7: A grant on a channel whose request bit is high removes one flit. In the next cycle, `credit_valid` is high for one cycle and `credit_vc` names that channel. A grant on a channel without a request is ignored, and no credit follows it.
- R8: `credit_free` is high exactly when the removed flit was TAIL or HEAD_TAIL. The channel is then idle in the cycle the credit is shown.
- R9: The virtual network of channel c is c / VCS_PER_VNET. Each accepted flit adds one to both the write counter and the read counter of its network. The counter for network k sits at bits [k*CNT_W +: CNT_W] of `buf_writes` and `buf_reads`.
- R10: `cnt_clear` zeroes all counters at the next edge. It takes priority over an increment in the same cycle, and it does not affect flit acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A flit is present on the link |
| in_kind | input | 2 | Flit kind: 0 head, 1 body, 2 tail, 3 head-tail |
| in_vc | input | VC_W | Virtual channel of the flit |
| in_dest | input | DEST_W | Destination field used by route computation |
| in_data | input | DATA_W | Flit payload |
| grant_valid | input | 1 | Switch allocator grants a channel |
| grant_vc | input | VC_W | Granted channel; also selects the out_* view |
| cnt_clear | input | 1 | Synchronous clear of the buffer counters |
| sa_req | output | NUM_VCS | Per-channel request to switch allocation |
| out_data | output | DATA_W | Oldest payload of the selected channel |
| out_kind | output | 2 | Oldest flit kind of the selected channel |
| out_port | output | PORT_W | Stored output port of the selected channel |
| vc_active | output | NUM_VCS | Per-channel packet state, 1 = active |
| credit_valid | output | 1 | Credit to upstream this cycle |
| credit_vc | output | VC_W | Channel the credit belongs to |
| credit_free | output | 1 | Channel was freed by the departing flit |
| proto_err | output | 1 | One-cycle pulse after a dropped flit |
| buf_writes | output | NUM_VNETS*CNT_W | Per-network buffer write counts |
| buf_reads | output | NUM_VNETS*CNT_W | Per-network buffer read counts |

## Verification
The assertions assume that `grant_vc` is in range whenever `grant_valid` is high. They also assume that the upstream sender never has more flits outstanding than a FIFO can hold, so the only full-FIFO drops are the ones the stimulus makes on purpose. The bench keeps every grant on a valid channel index. It makes protocol violations only as single, deliberate flits, so that each error pulse can be linked to the flit that caused it. It also grants channels that are not yet requesting, to show that such grants have no effect.

// File: rtl/vc_input_port.sv
module vc_input_port #(
  parameter int NUM_VNETS    = 2,
  parameter int VCS_PER_VNET = 2,
  parameter int DEPTH        = 4,
  parameter int STAGES       = 3,
  parameter int NUM_PORTS    = 4,
  parameter int DEST_W       = 4,
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 8,
  localparam int NUM_VCS = NUM_VNETS * VCS_PER_VNET,
  localparam int VC_W    = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1,
  localparam int PORT_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [1:0]                 in_kind,
  input  logic [VC_W-1:0]            in_vc,
  input  logic [DEST_W-1:0]          in_dest,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       grant_valid,
  input  logic [VC_W-1:0]            grant_vc,
  input  logic                       cnt_clear,
  output logic [NUM_VCS-1:0]         sa_req,
  output logic [DATA_W-1:0]          out_data,
  output logic [1:0]                 out_kind,
  output logic [PORT_W-1:0]          out_port,
  output logic [NUM_VCS-1:0]         vc_active,
  output logic                       credit_valid,
  output logic [VC_W-1:0]            credit_vc,
  output logic                       credit_free,
  output logic                       proto_err,
  output logic [NUM_VNETS*CNT_W-1:0] buf_writes,
  output logic [NUM_VNETS*CNT_W-1:0] buf_reads
);

  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam int WAIT_W = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam int VN_W   = (NUM_VNETS > 1) ? $clog2(NUM_VNETS) : 1;
  localparam logic [1:0] K_HEAD = 2'd0, K_TAIL = 2'd2, K_HT = 2'd3;
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(STAGES - 1);

  logic [DATA_W-1:0] mem   [NUM_VCS][DEPTH];
  logic [1:0]        mkind [NUM_VCS][DEPTH];
  logic [WAIT_W-1:0] mwait [NUM_VCS][DEPTH];
  logic [PTR_W-1:0]  wr_ptr [NUM_VCS];
  logic [PTR_W-1:0]  rd_ptr [NUM_VCS];
  logic [OCC_W-1:0]  occ    [NUM_VCS];
  logic [PORT_W-1:0] port_q [NUM_VCS];
  logic [NUM_VCS-1:0] active;
  logic [CNT_W-1:0]  wcnt [NUM_VNETS];
  logic [CNT_W-1:0]  rcnt [NUM_VNETS];

  wire in_is_head = (in_kind == K_HEAD) || (in_kind == K_HT);
  wire in_range   = 32'(in_vc) < NUM_VCS;
  wire in_full    = occ[in_vc] == OCC_W'(DEPTH);
  wire in_bad     = !in_range || in_full || (in_is_head ? active[in_vc] : !active[in_vc]);
  wire accept     = in_valid && !in_bad;
  wire g_range    = 32'(grant_vc) < NUM_VCS;
  wire pop_ok     = grant_valid && g_range && sa_req[grant_vc];
  wire [1:0] pop_kind = mkind[grant_vc][rd_ptr[grant_vc]];
  wire pop_last   = (pop_kind == K_TAIL) || (pop_kind == K_HT);
  wire [PORT_W-1:0] route_port = PORT_W'(in_dest % DEST_W'(NUM_PORTS));
  wire [VN_W-1:0]   in_vnet    = VN_W'(in_vc / VC_W'(VCS_PER_VNET));

  assign out_data  = mem[grant_vc][rd_ptr[grant_vc]];
  assign out_kind  = pop_kind;
  assign out_port  = port_q[grant_vc];
  assign vc_active = active;

  generate
    for (genvar v = 0; v < NUM_VCS; v++) begin : g_req
      assign sa_req[v] = (occ[v] != '0) && (mwait[v][rd_ptr[v]] == '0);
    end
    for (genvar k = 0; k < NUM_VNETS; k++) begin : g_cnt_out
      assign buf_writes[k*CNT_W +: CNT_W] = wcnt[k];
      assign buf_reads[k*CNT_W +: CNT_W]  = rcnt[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int v = 0; v < NUM_VCS; v++)
      for (int e = 0; e < DEPTH; e++)
        if (mwait[v][e] != '0) mwait[v][e] <= mwait[v][e] - 1'b1;
    if (accept) begin
      mem[in_vc][wr_ptr[in_vc]]   <= in_data;
      mkind[in_vc][wr_ptr[in_vc]] <= in_kind;
      mwait[in_vc][wr_ptr[in_vc]] <= WAIT_INIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= '0;
      credit_valid <= 1'b0;
      credit_vc    <= '0;
      credit_free  <= 1'b0;
      proto_err    <= 1'b0;
      for (int v = 0; v < NUM_VCS; v++) begin
        wr_ptr[v] <= '0;
        rd_ptr[v] <= '0;
        occ[v]    <= '0;
        port_q[v] <= '0;
      end
      for (int k = 0; k < NUM_VNETS; k++) begin
        wcnt[k] <= '0;
        rcnt[k] <= '0;
      end
    end else begin
      proto_err    <= in_valid && in_bad;
      credit_valid <= pop_ok;
      if (pop_ok) begin
        credit_vc   <= grant_vc;
        credit_free <= pop_last;
      end
      for (int v = 0; v < NUM_VCS; v++) begin
        automatic logic wr_v = accept && (in_vc == VC_W'(v));
        automatic logic rd_v = pop_ok && (grant_vc == VC_W'(v));
        occ[v] <= occ[v] + OCC_W'(wr_v) - OCC_W'(rd_v);
        if (wr_v) begin
          wr_ptr[v] <= (wr_ptr[v] == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr[v] + 1'b1;
          if (in_is_head) begin
            active[v] <= 1'b1;
            port_q[v] <= route_port;
          end
        end
        if (rd_v) begin
          rd_ptr[v] <= (rd_ptr[v] == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr[v] + 1'b1;
          if (pop_last) active[v] <= 1'b0;
        end
      end
      for (int k = 0; k < NUM_VNETS; k++) begin
        if (cnt_clear) begin
          wcnt[k] <= '0;
          rcnt[k] <= '0;
        end else if (accept && in_vnet == VN_W'(k)) begin
          wcnt[k] <= wcnt[k] + 1'b1;
          rcnt[k] <= rcnt[k] + 1'b1;
        end
      end
    end
  end

  p_credit_follows_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> credit_valid && credit_vc == $past(grant_vc));
  p_no_credit_without_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_ok |=> !credit_valid);
  p_free_means_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    credit_valid && credit_free |-> !active[credit_vc]);
  p_head_on_active_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_is_head && in_range && active[in_vc] |=> proto_err);

  generate
    for (genvar v = 0; v < NUM_VCS; v++) begin : g_chk
      p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        occ[v] <= OCC_W'(DEPTH));
      p_req_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sa_req[v] && !(pop_ok && grant_vc == VC_W'(v)) |=> sa_req[v]);
    end
  endgenerate

endmodule

// File: tb/test_vc_input_port.sv
`timescale 1ns/1ps
module test_vc_input_port;
  localparam int NV = 2, VPV = 2, DEPTH = 4, STAGES = 3, NP = 4;
  localparam int DW = 4, DATAW = 8, CW = 8, NVC = NV * VPV;
  localparam int NVEC = 6;
  localparam logic [1:0] V_VC   [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd2, 2'd0};
  localparam logic [3:0] V_DEST [NVEC] = '{4'd5, 4'd10, 4'd3, 4'd12, 4'd15, 4'd0};
  localparam logic [7:0] V_DATA [NVEC] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, grant_valid = 1'b0, cnt_clear = 1'b0;
  logic [1:0] in_kind = '0, in_vc = '0, grant_vc = '0;
  logic [DW-1:0] in_dest = '0;
  logic [DATAW-1:0] in_data = '0;
  logic [NVC-1:0] sa_req, vc_active;
  logic [DATAW-1:0] out_data;
  logic [1:0] out_kind, out_port, credit_vc;
  logic credit_valid, credit_free, proto_err;
  logic [NV*CW-1:0] buf_writes, buf_reads;
  int checks = 0, errors = 0;
  int exp_cnt [NV] = '{0, 0};

  always #2 clk = ~clk;

  vc_input_port #(.NUM_VNETS(NV), .VCS_PER_VNET(VPV), .DEPTH(DEPTH), .STAGES(STAGES),
    .NUM_PORTS(NP), .DEST_W(DW), .DATA_W(DATAW), .CNT_W(CW)) i_vc_input_port (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind), .in_vc(in_vc),
    .in_dest(in_dest), .in_data(in_data), .grant_valid(grant_valid), .grant_vc(grant_vc),
    .cnt_clear(cnt_clear), .sa_req(sa_req), .out_data(out_data), .out_kind(out_kind),
    .out_port(out_port), .vc_active(vc_active), .credit_valid(credit_valid),
    .credit_vc(credit_vc), .credit_free(credit_free), .proto_err(proto_err),
    .buf_writes(buf_writes), .buf_reads(buf_reads));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(int vc, int kind, int dest, int data, bit good);
    in_valid = 1'b1; in_vc = 2'(vc); in_kind = 2'(kind);
    in_dest = DW'(dest); in_data = DATAW'(data);
    @(negedge clk);
    in_valid = 1'b0;
    if (good) exp_cnt[vc / VPV]++;
  endtask

  task automatic check_counts(string req);
    for (int k = 0; k < NV; k++) begin
      chk(req, "write count", int'(buf_writes[k*CW +: CW]), exp_cnt[k]);
      chk(req, "read count", int'(buf_reads[k*CW +: CW]), exp_cnt[k]);
    end
  endtask

  task automatic await_req(int vc, string req);
    for (int i = 0; i < STAGES - 1; i++) begin
      chk(req, "request before latency", int'(sa_req[vc]), 0);
      @(negedge clk);
    end
    chk(req, "request after latency", int'(sa_req[vc]), 1);
  endtask

  task automatic grant(int vc, int data, int port, int kind, int free, string req);
    grant_valid = 1'b1; grant_vc = 2'(vc);
    #1;
    chk(req, "out_data", int'(out_data), data);
    chk(req, "out_port", int'(out_port), port);
    chk(req, "out_kind", int'(out_kind), kind);
    @(negedge clk);
    grant_valid = 1'b0;
    chk("R7", "credit_valid", int'(credit_valid), 1);
    chk("R7", "credit_vc", int'(credit_vc), vc);
    chk("R8", "credit_free", int'(credit_free), free);
    if (free != 0) chk("R8", "channel idle with free credit", int'(vc_active[vc]), 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sa_req", int'(sa_req), 0);
    chk("R1", "vc_active", int'(vc_active), 0);
    chk("R1", "credit_valid", int'(credit_valid), 0);
    chk("R1", "proto_err", int'(proto_err), 0);
    check_counts("R1");

    for (int n = 0; n < NVEC; n++) begin
      send(V_VC[n], 3, V_DEST[n], V_DATA[n], 1'b1);
      chk("R2", "active after head", int'(vc_active[V_VC[n]]), 1);
      await_req(V_VC[n], "R5");
      grant(V_VC[n], V_DATA[n], V_DEST[n] % NP, 3, 1, "R2");
      check_counts("R9");
    end

    // multi-flit packet: port comes from head only (R3), order kept (R6)
    send(1, 0, 6, 8'hA1, 1'b1);
    send(1, 1, 1, 8'hA2, 1'b1);
    send(1, 2, 3, 8'hA3, 1'b1);
    repeat (STAGES) @(negedge clk);
    grant(1, 8'hA1, 2, 0, 0, "R6");
    chk("R8", "active after head leaves", int'(vc_active[1]), 1);
    grant(1, 8'hA2, 2, 1, 0, "R3");
    grant(1, 8'hA3, 2, 2, 1, "R3");

    // grant before eligibility is ignored (R5, R7)
    send(3, 0, 9, 8'hB1, 1'b1);
    grant_valid = 1'b1; grant_vc = 2'd3;
    @(negedge clk);
    grant_valid = 1'b0;
    chk("R7", "no credit for early grant", int'(credit_valid), 0);
    @(negedge clk);
    chk("R5", "request raised at latency", int'(sa_req[3]), 1);
    grant(3, 8'hB1, 1, 0, 0, "R7");

    // protocol violations (R4)
    send(3, 3, 2, 8'hC1, 1'b0);
    chk("R4", "head on active channel", int'(proto_err), 1);
    send(0, 1, 2, 8'hC2, 1'b0);
    chk("R4", "body on idle channel", int'(proto_err), 1);
    @(negedge clk);
    chk("R4", "error pulse one cycle", int'(proto_err), 0);
    repeat (STAGES) @(negedge clk);
    chk("R4", "dropped body not buffered", int'(sa_req[0]), 0);
    chk("R4", "dropped body leaves idle", int'(vc_active[0]), 0);
    check_counts("R4");
    send(3, 2, 0, 8'hB2, 1'b1);
    repeat (STAGES) @(negedge clk);
    grant(3, 8'hB2, 1, 2, 1, "R8");

    // full FIFO (R4, R6)
    send(2, 0, 7, 8'hD0, 1'b1);
    for (int i = 1; i < DEPTH; i++) send(2, 1, 0, 8'hD0 + i, 1'b1);
    chk("R4", "no error while filling", int'(proto_err), 0);
    send(2, 1, 0, 8'hDF, 1'b0);
    chk("R4", "write to full FIFO", int'(proto_err), 1);
    check_counts("R4");
    repeat (STAGES) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) grant(2, 8'hD0 + i, 3, (i == 0) ? 0 : 1, 0, "R6");
    chk("R6", "fifo drained", int'(sa_req[2]), 0);
    send(2, 2, 0, 8'hD9, 1'b1);
    repeat (STAGES) @(negedge clk);
    grant(2, 8'hD9, 3, 2, 1, "R8");
    check_counts("R9");

    // clear wins over same-cycle increment (R10)
    cnt_clear = 1'b1;
    send(0, 3, 4, 8'hE1, 1'b1);
    cnt_clear = 1'b0;
    exp_cnt = '{0, 0};
    check_counts("R10");
    chk("R10", "flit still accepted", int'(vc_active[0]), 1);
    repeat (STAGES - 1) @(negedge clk);
    grant(0, 8'hE1, 0, 3, 1, "R10");
    check_counts("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule